// File: doc/BRIEF.md
# Scan-Testable Register Bank

This block is a bank of functional storage flops in which every flop has been turned into a multiplexed-input scan cell. The cells are stitched into a single serial chain that runs from `scan_in` through cell 0 up to cell N-1, whose output drives `scan_out`. Each cell normally loads a functional next value: the read data of a small storage macro, XORed with the contents of an embedded latch. That load is gated by a clock-gate cell.

When `test_mode` is high, the block applies the usual test-mode design rules to itself:

- The clock-gate enable is forced on.
- An internally generated clear cannot reach the cells' asynchronous reset, so only `rst_n` resets them.
- The latch is held transparent.
- The storage macro is bypassed, so its write data appears directly at its read output.

With `scan_en` also high, the cells shift instead of loading. All storage uses the single primary clock, and no clock feeds any data path. A tester uses the block in three steps: it shifts a pattern in, drops `scan_en` for one capture edge, then shifts the captured response out while the next pattern shifts in.

Top module: `scan_reg_bank`

## Requirements
- R1: While `rst_n` is low, every cell reads 0 and `scan_out` is 0, whatever the mode.
- R2: With `test_mode` low and `func_en` high, each clock edge loads `bank_q` with (macro read data XOR latch value). With `test_mode` low and `func_en` low, `bank_q` holds.
- R3: With `test_mode` low, `scan_en` has no effect: the bank loads or holds exactly as R2 states.
- R4: With `test_mode` and `scan_en` both high, each edge moves cell i-1 into cell i and `scan_in` into cell 0. `scan_out` always equals cell N-1.
- R5: After a capture, N shift edges present the captured bits on `scan_out` in the order cell N-1 down to cell 0. The first bit is visible before the first shift edge. The N bits shifted in end up with the first one in cell N-1.
- R6: With `test_mode` high and `scan_en` low, each edge captures the functional value even when `func_en` is low, because the clock gate is forced open.
- R7: A high `clr_req` sampled at an edge while `test_mode` is low clears all cells right after that edge. The cells stay cleared until the next edge, and the load at that next edge is lost. While `test_mode` is high, `clr_req` has no effect on the cells.
- R8: The latch value follows `lat_d` while `lat_open` or `test_mode` is high, and holds otherwise.
- R9: With `test_mode` low, the macro read data is the entry at `mem_raddr`. A write at `mem_waddr` becomes visible from the edge after it. With `test_mode` high, the macro read data equals `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single primary clock for every flop |
| rst_n | input | 1 | Top-level asynchronous reset, active low |
| test_mode | input | 1 | Selects scan test mode and its overrides |
| scan_en | input | 1 | Shift select, honoured only in test mode |
| scan_in | input | 1 | Serial input into cell 0 |
| scan_out | output | 1 | Serial output, the value of cell N-1 |
| func_en | input | 1 | Functional clock-gate enable |
| clr_req | input | 1 | Functional clear request, registered internally |
| lat_open | input | 1 | Latch gate, active high |
| lat_d | input | N | Latch data |
| mem_we | input | 1 | Macro write enable |
| mem_waddr | input | AW | Macro write address |
| mem_wdata | input | N | Macro write data, also the bypass source |
| mem_raddr | input | AW | Macro read address |
| bank_q | output | N | Parallel view of all cells, bit i is cell i |

## Verification
The bound checker checks these on every clock:

- the shift relation between neighbouring cells;
- the capture and hold rules;
- the forced clock-gate enable;
- the blocking of the internal clear;
- latch transparency and macro bypass in test mode.

Only the bench's scenarios can show the rest:

- the unload order across a full chain;
- that `scan_en` is harmless in functional mode;
- that a closed latch keeps its old value;
- that a macro write is read back one edge later;
- that a clear request raised in test mode leaves the bank intact.

// File: rtl/scan_bank_pkg.sv
package scan_bank_pkg;

    typedef enum logic [1:0] {
        CELL_HOLD  = 2'd0,
        CELL_LOAD  = 2'd1,
        CELL_SHIFT = 2'd2
    } cell_op_e;

    // Shift wins only in test mode; otherwise the gated enable decides.
    function automatic cell_op_e pick_op(logic tm, logic se, logic gate_en);
        if (tm && se) begin
            return CELL_SHIFT;
        end
        if (gate_en) begin
            return CELL_LOAD;
        end
        return CELL_HOLD;
    endfunction

endpackage

// File: rtl/scan_cg_cell.sv
// Clock-gate cell model expressed as a load enable on the primary clock.
module scan_cg_cell (
    input  logic func_en,
    input  logic test_mode,
    output logic gate_en
);
    assign gate_en = func_en | test_mode;
endmodule

// File: rtl/scan_rst_ctrl.sv
// Registers the functional clear and merges it into the cell reset,
// except in test mode where only the port-level reset reaches the cells.
module scan_rst_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic clr_req,
    output logic cell_rst_n
);
    typedef struct packed {
        logic clr;
    } clr_state_t;

    clr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = clr_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cell_rst_n = rst_n & (test_mode | ~st_q.clr);
endmodule

// File: rtl/scan_latch_bank.sv
// Embedded level-sensitive latch, held transparent in test mode.
module scan_latch_bank #(
    parameter int N = 8
) (
    input  logic         test_mode,
    input  logic         open,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_latch begin
        if (open || test_mode) begin
            q <= d;
        end
    end
endmodule

// File: rtl/scan_macro_stub.sv
// Small storage macro stand-in with a test-mode bypass from write data to read data.
module scan_macro_stub #(
    parameter int N     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          test_mode,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [N-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [N-1:0]  rdata
);
    logic [N-1:0] mem_d [DEPTH];
    logic [N-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = test_mode ? wdata : mem_q[raddr];
endmodule

// File: rtl/scan_reg_bank.sv
module scan_reg_bank
    import scan_bank_pkg::*;
#(
    parameter int N     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          scan_en,
    input  logic          scan_in,
    output logic          scan_out,
    input  logic          func_en,
    input  logic          clr_req,
    input  logic          lat_open,
    input  logic [N-1:0]  lat_d,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_waddr,
    input  logic [N-1:0]  mem_wdata,
    input  logic [AW-1:0] mem_raddr,
    output logic [N-1:0]  bank_q
);
    typedef struct packed {
        logic [N-1:0] cells;
    } bank_t;

    bank_t        st_d, st_q;
    logic         gate_en;
    logic         cell_rst_n;
    logic [N-1:0] lat_q;
    logic [N-1:0] mac_q;
    logic [N-1:0] func_d;
    logic [N-1:0] chain_src;

    scan_cg_cell u_cg (
        .func_en   (func_en),
        .test_mode (test_mode),
        .gate_en   (gate_en)
    );

    scan_rst_ctrl u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .clr_req    (clr_req),
        .cell_rst_n (cell_rst_n)
    );

    scan_latch_bank #(.N(N)) u_lat (
        .test_mode (test_mode),
        .open      (lat_open),
        .d         (lat_d),
        .q         (lat_q)
    );

    scan_macro_stub #(.N(N), .DEPTH(DEPTH)) u_mac (
        .clk       (clk),
        .test_mode (test_mode),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .raddr     (mem_raddr),
        .rdata     (mac_q)
    );

    assign func_d = mac_q ^ lat_q;

    // Stitching: cell 0 takes the serial input, every other cell its lower neighbour.
    for (genvar i = 0; i < N; i++) begin : g_stitch
        if (i == 0) begin : g_head
            assign chain_src[i] = scan_in;
        end else begin : g_link
            assign chain_src[i] = st_q.cells[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (pick_op(test_mode, scan_en, gate_en))
            CELL_SHIFT: st_d.cells = chain_src;
            CELL_LOAD:  st_d.cells = func_d;
            default:    st_d       = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge cell_rst_n) begin
        if (!cell_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q   = st_q.cells;
    assign scan_out = st_q.cells[N-1];
endmodule

// File: rtl/scan_reg_bank_chk.sv
module scan_reg_bank_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_mode,
    input logic         scan_en,
    input logic         scan_in,
    input logic         func_en,
    input logic         clr_req,
    input logic [N-1:0] lat_d,
    input logic [N-1:0] mem_wdata,
    input logic [N-1:0] bank_q,
    input logic         cg_en,
    input logic         cell_rst_n,
    input logic [N-1:0] lat_q,
    input logic [N-1:0] mac_q
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !func_en && cell_rst_n) |=> (!cell_rst_n || bank_q == $past(bank_q)));

    assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && scan_en) |=>
            (!cell_rst_n || bank_q == {$past(bank_q[N-2:0]), $past(scan_in)}));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !scan_en) |=> (!cell_rst_n || bank_q == $past(mac_q ^ lat_q)));

    assert_gate_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> cg_en);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && clr_req) |=> (test_mode || bank_q == '0));

    assert_rst_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> cell_rst_n);

    assert_latch_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (lat_q == lat_d));

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (mac_q == mem_wdata));
endmodule

bind scan_reg_bank scan_reg_bank_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode  (test_mode),
    .scan_en    (scan_en),
    .scan_in    (scan_in),
    .func_en    (func_en),
    .clr_req    (clr_req),
    .lat_d      (lat_d),
    .mem_wdata  (mem_wdata),
    .bank_q     (bank_q),
    .cg_en      (gate_en),
    .cell_rst_n (cell_rst_n),
    .lat_q      (lat_q),
    .mac_q      (mac_q)
);

// File: tb/scan_reg_bank_tb.sv
module scan_reg_bank_tb;
    localparam int N     = 8;
    localparam int DEPTH = 4;
    localparam int AW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic          func_en = 1'b0;
    logic          clr_req = 1'b0;
    logic          lat_open = 1'b0;
    logic [N-1:0]  lat_d = '0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [N-1:0]  mem_wdata = '0;
    logic [AW-1:0] mem_raddr = '0;
    logic [N-1:0]  bank_q;

    int    total = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    scan_reg_bank #(.N(N), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
        .scan_in(scan_in), .scan_out(scan_out), .func_en(func_en), .clr_req(clr_req),
        .lat_open(lat_open), .lat_d(lat_d), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .bank_q(bank_q)
    );

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] memval(int i);
        return N'(8'h3C + i * 8'h51);
    endfunction

    // Behavioural reference: queue of cell bits, index 0 is cell 0.
    logic         m_q[$];
    logic [N-1:0] mem_m [DEPTH];
    logic [N-1:0] lat_m;
    logic         clr_m = 1'b0;

    function automatic logic [N-1:0] model_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_q[i];
        return v;
    endfunction

    task automatic model_fill(logic [N-1:0] v);
        m_q.delete();
        for (int i = 0; i < N; i++) m_q.push_back(v[i]);
    endtask

    initial model_fill('0);

    always @(posedge clk) begin
        logic [N-1:0] mac;
        logic         rst_act;
        if (!rst_n) begin
            model_fill('0);
            clr_m = 1'b0;
        end else begin
            rst_act = clr_m && !test_mode;
            if (test_mode || lat_open) lat_m = lat_d;
            mac = test_mode ? mem_wdata : mem_m[mem_raddr];
            if (!rst_act) begin
                if (test_mode && scan_en) begin
                    m_q.push_front(scan_in);
                    void'(m_q.pop_back());
                end else if (test_mode || func_en) begin
                    model_fill(mac ^ lat_m);
                end
            end
            if (mem_we) mem_m[mem_waddr] = mem_wdata;
            clr_m = clr_req;
            if (clr_m && !test_mode) model_fill('0);
        end
        #2;
        if (!done) begin
            chk(cur_req, bank_q, model_vec());
            chk(cur_req, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_q[N-1]});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic after_edge();
        @(posedge clk);
        #3;
    endtask

    initial begin
        logic [N-1:0] lat_cur;
        logic [N-1:0] cap;
        logic [N-1:0] pat;

        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #3;
        chk("R1", bank_q, '0);
        chk("R1", {{(N-1){1'b0}}, scan_out}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Setup: open latch, fill macro
        cur_req = "R9";
        lat_cur = 8'hA5;
        lat_open = 1'b1;
        lat_d = lat_cur;
        for (int i = 0; i < DEPTH; i++) begin
            mem_we = 1'b1;
            mem_waddr = AW'(i);
            mem_wdata = memval(i);
            @(negedge clk);
        end
        mem_we = 1'b0;
        lat_open = 1'b0;

        // R2: functional load and hold
        cur_req = "R2";
        mem_raddr = 2'd2;
        func_en = 1'b1;
        after_edge();
        chk("R2", bank_q, memval(2) ^ lat_cur);
        @(negedge clk);
        func_en = 1'b0;
        mem_raddr = 2'd1;
        after_edge();
        chk("R2", bank_q, memval(2) ^ lat_cur);

        // R3: scan_en ignored outside test mode
        cur_req = "R3";
        @(negedge clk);
        scan_en = 1'b1;
        scan_in = 1'b1;
        func_en = 1'b1;
        after_edge();
        chk("R3", bank_q, memval(1) ^ lat_cur);
        @(negedge clk);
        func_en = 1'b0;
        after_edge();
        chk("R3", bank_q, memval(1) ^ lat_cur);

        // R8: closed latch keeps old value, opening takes new
        cur_req = "R8";
        @(negedge clk);
        scan_en = 1'b0;
        scan_in = 1'b0;
        lat_d = 8'h0F;
        mem_raddr = 2'd3;
        func_en = 1'b1;
        after_edge();
        chk("R8", bank_q, memval(3) ^ lat_cur);
        @(negedge clk);
        lat_open = 1'b1;
        after_edge();
        lat_cur = 8'h0F;
        chk("R8", bank_q, memval(3) ^ lat_cur);
        @(negedge clk);
        lat_open = 1'b0;

        // R9: write visible from the next edge
        cur_req = "R9";
        mem_we = 1'b1;
        mem_waddr = 2'd0;
        mem_wdata = 8'hC3;
        mem_raddr = 2'd0;
        after_edge();
        chk("R9", bank_q, memval(0) ^ lat_cur);
        @(negedge clk);
        mem_we = 1'b0;
        after_edge();
        chk("R9", bank_q, 8'hC3 ^ lat_cur);

        // R7: functional clear
        cur_req = "R7";
        @(negedge clk);
        clr_req = 1'b1;
        after_edge();
        chk("R7", bank_q, '0);
        @(negedge clk);
        clr_req = 1'b0;
        after_edge();
        chk("R7", bank_q, '0);
        after_edge();
        chk("R7", bank_q, 8'hC3 ^ lat_cur);

        // R6/R8/R9: capture in test mode with gate forced, latch open, macro bypassed
        cur_req = "R6";
        @(negedge clk);
        func_en = 1'b0;
        test_mode = 1'b1;
        lat_d = 8'h5A;
        mem_wdata = 8'h96;
        after_edge();
        chk("R6", bank_q, 8'h96 ^ 8'h5A);

        // R7: clear blocked in test mode
        cur_req = "R7";
        @(negedge clk);
        clr_req = 1'b1;
        mem_wdata = 8'h33;
        after_edge();
        chk("R7", bank_q, 8'h33 ^ 8'h5A);
        @(negedge clk);
        clr_req = 1'b0;
        after_edge();
        chk("R7", bank_q, 8'h33 ^ 8'h5A);

        // R4/R5: unload captured bits while loading a new pattern
        cur_req = "R5";
        cap = 8'h33 ^ 8'h5A;
        pat = 8'hB2;
        @(negedge clk);
        scan_en = 1'b1;
        for (int k = 0; k < N; k++) begin
            scan_in = pat[N-1-k];
            #1;
            chk("R5", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, cap[N-1-k]});
            @(negedge clk);
        end
        chk("R4", bank_q, pat);
        scan_en = 1'b0;
        test_mode = 1'b0;
        cur_req = "R2";
        after_edge();
        chk("R2", bank_q, pat);

        // R1: reset mid-run
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", bank_q, '0);
        after_edge();
        chk("R1", bank_q, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule